// File: doc/BRIEF.md
# Bus Even-Parity Generator and Checker

This block computes and checks the parity bit of a parallel bus that carries a 32-bit multiplexed address/data field and a 4-bit command/byte-enable field. The parity bit makes the number of ones across the data field, the enable field and the parity bit itself even. The parity bit lags the values it covers by one clock. A bus monitor supplies the address-phase marker, the initiator-ready indication and the transfer direction. The datapath supplies the enable of its own data-field drivers.

As a receiver, the block checks the parity bit that arrives one clock after an address phase and one clock after each write cycle in which initiator-ready is high. A mismatch produces a single-cycle error pulse. As a driver, the block always presents the parity of the previous cycle's bus values. The parity output-enable follows the data-field output-enable one cycle later. Parity is therefore driven one clock after read data, and also while the agent parks on an idle bus that it has been granted. Both the enable and the release of the parity driver lag the data-field driver by one cycle.

Top module: `pci_parity_unit`

## Requirements
- R1: While rst_ni is low, par_o, par_oe_o and perr_o are all 0.
- R2: In every cycle, par_o equals the XOR of all 32 ad_i bits and all 4 cbe_i bits sampled at the previous rising clock edge. This makes ad, cbe and par together contain an even number of ones.
- R3: par_oe_o equals ad_oe_i from the previous clock. It rises one cycle after ad_oe_i rises and falls one cycle after ad_oe_i falls.
- R4: A cycle with addr_vld_i high is a checked cycle. If par_i in the next cycle differs from the even parity of that cycle's ad_i and cbe_i, perr_o is high in the cycle after that. This is two clocks after the checked cycle.
- R5: A cycle with irdy_i high and we_i high (write) is a checked cycle, with the same timing and rule as R4.
- R6: A cycle with irdy_i high and we_i low (read) and addr_vld_i low is not checked. A wrong par_i after it never raises perr_o.
- R7: When par_i in the cycle after a checked cycle matches the even parity of that cycle, perr_o stays 0.
- R8: A single-bit flip on any ad_i bit or any cbe_i bit in a checked cycle, or on par_i in the cycle that follows it, raises perr_o for exactly one cycle. Back-to-back checked cycles are flagged independently, one pulse per failing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Address/data field as seen on the bus |
| cbe_i | input | 4 | Command/byte-enable field as seen on the bus |
| par_i | input | 1 | Parity bit as seen on the bus |
| addr_vld_i | input | 1 | Address phase in this cycle |
| irdy_i | input | 1 | Initiator-ready in this cycle |
| we_i | input | 1 | 1 = write transfer, 0 = read transfer |
| ad_oe_i | input | 1 | This agent drives the address/data field in this cycle |
| par_o | output | 1 | Parity value to drive |
| par_oe_o | output | 1 | Parity output-enable |
| perr_o | output | 1 | One-cycle parity-error pulse |

## Verification
par_o and par_oe_o are due one clock after the bus values they cover. perr_o is due two clocks after a checked cycle, that is, one clock after the parity bit is sampled. The bench drives inputs on the falling edge and compares outputs on the next falling edge. It keeps a two-deep history of the intended values, the values actually driven onto the bus, and the check flags. From that history it computes the output expected at each falling edge. Fault injection flips one AD bit, one enable bit or the parity bit, and each flip is predicted from the same history.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  typedef struct packed {
    logic par;  // parity of previous-cycle ad/cbe
    logic chk;  // previous cycle must be checked
    logic oe;   // previous-cycle ad output-enable
  } par_stage_t;
endpackage

// File: rtl/pci_par_calc.sv
module pci_par_calc #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_i,
  output logic            par_o
);
  localparam int LANE_W = AD_W / BE_W;

  logic [BE_W-1:0] lane_par;

  // one byte lane plus its enable per leaf
  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_par[g] = (^ad_i[g*LANE_W +: LANE_W]) ^ cbe_i[g];
  end

  assign par_o = ^lane_par;
endmodule

// File: rtl/pci_par_stage.sv
module pci_par_stage
  import pci_par_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       par_i,
  input  logic       chk_i,
  input  logic       oe_i,
  output par_stage_t stage_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_o <= '0;
    else         stage_o <= '{par: par_i, chk: chk_i, oe: oe_i};
  end

  p_oe_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_i) |=> $rose(stage_o.oe));
  p_oe_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_i) |=> $fell(stage_o.oe));
endmodule

// File: rtl/pci_par_check.sv
module pci_par_check
  import pci_par_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  par_stage_t stage_i,
  input  logic       par_i,
  output logic       perr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) perr_o <= 1'b0;
    else         perr_o <= stage_i.chk & (stage_i.par ^ par_i);
  end

  p_match_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |-> ($past(par_i) != $past(stage_i.par)));
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_par_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_i,
  input  logic            par_i,
  input  logic            addr_vld_i,
  input  logic            irdy_i,
  input  logic            we_i,
  input  logic            ad_oe_i,
  output logic            par_o,
  output logic            par_oe_o,
  output logic            perr_o
);
  logic       cur_par;
  logic       chk_now;
  par_stage_t stage;

  pci_par_calc #(.AD_W(AD_W), .BE_W(BE_W)) calc_i (
    .ad_i (ad_i),
    .cbe_i(cbe_i),
    .par_o(cur_par)
  );

  // receiver role: address phases and write beats only
  assign chk_now = addr_vld_i | (irdy_i & we_i);

  pci_par_stage stage_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .par_i  (cur_par),
    .chk_i  (chk_now),
    .oe_i   (ad_oe_i),
    .stage_o(stage)
  );

  pci_par_check check_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stage_i(stage),
    .par_i  (par_i),
    .perr_o (perr_o)
  );

  assign par_o    = stage.par;
  assign par_oe_o = stage.oe;

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni |-> (!par_o && !par_oe_o && !perr_o)));
  p_gen_even_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones({$past(ad_i), $past(cbe_i), par_o}) % 2 == 0));
  p_err_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |-> $past(addr_vld_i | (irdy_i & we_i), 2));
  p_read_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |-> !$past(irdy_i & !we_i & !addr_vld_i, 2));
endmodule

// File: tb/pci_parity_unit_tb_top.sv
module pci_parity_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic        par = 1'b0, addr_vld = 1'b0, irdy = 1'b0, we = 1'b0, ad_oe = 1'b0;
  logic        par_o, par_oe_o, perr_o;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  // history: *1 = previous driven cycle, *2 = the one before
  bit pb1 = 0, pb2 = 0, ip1 = 0, pi1 = 0, chk1 = 0, chk2 = 0, oe1 = 0;
  int kind2 = 0, kind1 = 0;  // 0 idle, 4 addr, 5 write, 6 read

  always #5 clk = ~clk;

  pci_parity_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ad_i(ad), .cbe_i(cbe), .par_i(par),
    .addr_vld_i(addr_vld), .irdy_i(irdy), .we_i(we), .ad_oe_i(ad_oe),
    .par_o(par_o), .par_oe_o(par_oe_o), .perr_o(perr_o)
  );

  function automatic bit even_par(logic [31:0] a, logic [3:0] c);
    return ^{a, c};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // fault: 0 none, 1 ad bit, 2 cbe bit, 3 flip par for the previous cycle
  task automatic cycle(bit av, bit ir, bit w, bit oe, int fault, int fbit);
    logic [31:0] ia;
    logic [3:0]  ic;
    bit exp_err;
    string tag;
    @(negedge clk);
    check(par_o == pb1, "R2 par_o", par_o, pb1);
    check(par_oe_o == oe1, "R3 par_oe_o", par_oe_o, oe1);
    exp_err = chk2 && (pi1 != pb2);
    tag = (kind2 == 4) ? "R4 perr addr" : (kind2 == 5) ? "R5 perr write" :
          (kind2 == 6) ? "R6 perr read" : "R7 perr";
    if (!exp_err && chk2) tag = "R7 perr match";
    check(perr_o == exp_err, tag, perr_o, exp_err);
    if (perr_o) pulses++;
    pb2 = pb1; chk2 = chk1; kind2 = kind1;
    ia = $urandom; ic = 4'($urandom);
    ad = ia; cbe = ic;
    if (fault == 1) ad[fbit % 32] = ~ad[fbit % 32];
    if (fault == 2) cbe[fbit % 4] = ~cbe[fbit % 4];
    par = ip1 ^ (fault == 3);
    addr_vld = av; irdy = ir; we = w; ad_oe = oe;
    ip1 = even_par(ia, ic);
    pb1 = even_par(ad, cbe);
    pi1 = par;
    chk1 = av || (ir && w);
    oe1 = oe;
    kind1 = av ? 4 : (ir && w) ? 5 : ir ? 6 : 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(par_o == 0 && par_oe_o == 0 && perr_o == 0, "R1 reset",
          {par_o, par_oe_o, perr_o}, 0);
    rst_n = 1'b1;
    // directed: flips, each must give exactly one pulse (R8)
    pulses = 0;
    cycle(1, 0, 0, 0, 1, 31);  // addr with ad[31] flipped
    cycle(0, 1, 1, 0, 2, 3);   // write with cbe[3] flipped
    cycle(0, 1, 1, 0, 0, 0);   // write, clean
    cycle(0, 0, 0, 0, 3, 0);   // par flip for previous write
    cycle(0, 1, 0, 1, 1, 0);   // read with ad[0] flipped: ignored (R6)
    cycle(0, 0, 0, 1, 3, 0);   // flip par after read: ignored (R6)
    cycle(1, 0, 0, 0, 0, 0);   // clean addr (R7)
    cycle(0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0);
    check(pulses == 3, "R8 pulse count", pulses, 3);
    // R3 enable lag on toggling pattern
    cycle(0, 0, 0, 1, 0, 0);
    cycle(0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 1, 0, 0);
    // random mix, fixed seed
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 3);
      cycle(r == 0, r >= 2, r == 2, 1'($urandom), $urandom_range(0, 5) < 4 ?
            $urandom_range(0, 3) : 0, $urandom_range(0, 31));
    end
    cycle(0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule